// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block tracks a small, parameterized set of transmit message buffers for a CAN FD style controller. Each buffer owns a 4-bit state field in a packed state word. Each buffer also owns a 3-bit priority field, supplied from a priority word held outside the block. The host moves buffers between states with single-cycle command pulses. A command selects any subset of buffers and can request abort, set-ready and set-empty at the same time.

When the controller is enabled and no frame is in flight, the block picks the ready buffer with the highest non-zero priority. It offers that buffer's index to the bus side on a valid/ready handshake. When the bus side accepts, the block writes the outcome back into that buffer's state. It then raises one-cycle event pulses and, for a successful send, advances a frame counter. A not-full flag shows whether any buffer is free. Only one buffer is in flight at a time. The block keeps scanning and launching until no eligible buffer is left.

Top module: `txbuf_sched`

## Requirements
- R1: After reset every buffer state is EMPTY, `frame_cnt` is 0, `tx_valid` is low and `not_full` is high.
- R2: Buffer i's state sits in `state_word[4i+3:4i]` with codes EMPTY=0, READY=1, SENT=2, FAILED=3, ABORTED=4. Its priority sits in `prio_word[4i+2:4i]`, and bit 4i+3 is unused.
- R3: A command pulse (`cmd_valid`) acts on each buffer whose `cmd_sel` bit is set. It applies three steps in a fixed order:
  - abort turns READY into ABORTED;
  - set-ready then turns EMPTY, SENT, FAILED or ABORTED into READY;
  - set-empty then turns SENT, FAILED or ABORTED into EMPTY.
- R4: While `ctrl_en` is low, commands leave every state unchanged and no new transmission is offered.
- R5: The offered buffer is the READY buffer with the highest priority. A tie goes to the lowest index. A READY buffer at priority 0 is never offered.
- R6: Once raised, `tx_valid` stays high with a stable `tx_idx` until `tx_ready` is seen. At most one buffer is in flight.
- R7: Commands do not change the state of the buffer that is in flight, including in the cycle it is launched.
- R8: On the handshake cycle the in-flight buffer becomes FAILED if `tx_error` is high and SENT otherwise. `ev_txdone` pulses for one cycle after every completion. `ev_bufchg` pulses for one cycle after any cycle in which a state field changed.
- R9: `frame_cnt` rises by one after each successful (SENT) completion and wraps at its width. A `cnt_clr` pulse zeroes it and takes precedence over an increment in the same cycle.
- R10: `not_full` is high exactly when at least one buffer is EMPTY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; gates commands and new launches |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_sel | input | BUF_N | Buffer select mask for the command |
| cmd_abort | input | 1 | Abort request |
| cmd_set_ready | input | 1 | Set-ready request |
| cmd_set_empty | input | 1 | Set-empty request |
| prio_word | input | 4*BUF_N | Per-buffer priorities, 3 bits in each nibble |
| cnt_clr | input | 1 | Clear pulse for the frame counter |
| tx_valid | output | 1 | A buffer is offered for transmission |
| tx_idx | output | IDX_W | Index of the offered buffer |
| tx_ready | input | 1 | Bus side accepts and completes the offered frame |
| tx_error | input | 1 | Qualifies the completion as failed |
| state_word | output | 4*BUF_N | Packed buffer states |
| not_full | output | 1 | At least one buffer is EMPTY |
| frame_cnt | output | CNT_W | Successful transmit count |
| ev_txdone | output | 1 | Completion event pulse |
| ev_bufchg | output | 1 | Buffer state change event pulse |

## Verification
The assertions assume that the bus side raises `tx_ready` only while `tx_valid` is high, so that a completion always has a buffer in flight. They also assume that `tx_error` is looked at only on such a cycle. The stimulus keeps to this: `tx_ready` is raised only after `tx_valid` has been observed, or while a queue of expected launches is pending. Commands are applied as one-cycle pulses away from the clock edge. Priorities are changed only while nothing is in flight.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int unsigned FIELD_W = 4;

    typedef enum logic [FIELD_W-1:0] {
        ST_EMPTY   = 4'd0,
        ST_READY   = 4'd1,
        ST_SENT    = 4'd2,
        ST_FAILED  = 4'd3,
        ST_ABORTED = 4'd4
    } buf_state_e;

    // Ordered application of abort, set-ready, set-empty to one buffer.
    function automatic logic [FIELD_W-1:0] apply_cmd(
        input logic [FIELD_W-1:0] cur,
        input logic               do_abort,
        input logic               do_ready,
        input logic               do_empty
    );
        logic [FIELD_W-1:0] s;
        s = cur;
        if (do_abort && s == ST_READY) begin
            s = ST_ABORTED;
        end
        if (do_ready && (s == ST_EMPTY || s == ST_SENT ||
                         s == ST_FAILED || s == ST_ABORTED)) begin
            s = ST_READY;
        end
        if (do_empty && (s == ST_SENT || s == ST_FAILED || s == ST_ABORTED)) begin
            s = ST_EMPTY;
        end
        return s;
    endfunction

endpackage

// File: rtl/txs_cmd_unit.sv
module txs_cmd_unit
    import txs_pkg::*;
#(
    parameter int unsigned BUF_N = 4
) (
    input  logic [FIELD_W*BUF_N-1:0] cur_word,
    input  logic [BUF_N-1:0]         apply_mask,
    input  logic                     do_abort,
    input  logic                     do_ready,
    input  logic                     do_empty,
    output logic [FIELD_W*BUF_N-1:0] nxt_word
);

    for (genvar g = 0; g < BUF_N; g++) begin : g_buf
        always_comb begin
            if (apply_mask[g]) begin
                nxt_word[g*FIELD_W +: FIELD_W] =
                    apply_cmd(cur_word[g*FIELD_W +: FIELD_W], do_abort, do_ready, do_empty);
            end else begin
                nxt_word[g*FIELD_W +: FIELD_W] = cur_word[g*FIELD_W +: FIELD_W];
            end
        end
    end

endmodule

// File: rtl/txs_picker.sv
module txs_picker
    import txs_pkg::*;
#(
    parameter int unsigned BUF_N  = 4,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned IDX_W = (BUF_N > 1) ? $clog2(BUF_N) : 1
) (
    input  logic [FIELD_W*BUF_N-1:0] state_word,
    input  logic [FIELD_W*BUF_N-1:0] prio_word,
    output logic                     found,
    output logic [IDX_W-1:0]         pick_idx
);

    logic [PRIO_W-1:0] best;

    // Strictly-greater scan from a floor of zero: ties keep the lower index.
    always_comb begin
        best     = '0;
        found    = 1'b0;
        pick_idx = '0;
        for (int i = 0; i < BUF_N; i++) begin
            if (state_word[i*FIELD_W +: FIELD_W] == ST_READY &&
                prio_word[i*FIELD_W +: PRIO_W] > best) begin
                best     = prio_word[i*FIELD_W +: PRIO_W];
                found    = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/txbuf_sched.sv
module txbuf_sched
    import txs_pkg::*;
#(
    parameter int unsigned BUF_N  = 4,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned CNT_W  = 32,
    localparam int unsigned IDX_W = (BUF_N > 1) ? $clog2(BUF_N) : 1,
    localparam int unsigned WORD_W = FIELD_W * BUF_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              cmd_valid,
    input  logic [BUF_N-1:0]  cmd_sel,
    input  logic              cmd_abort,
    input  logic              cmd_set_ready,
    input  logic              cmd_set_empty,
    input  logic [WORD_W-1:0] prio_word,
    input  logic              cnt_clr,
    output logic              tx_valid,
    output logic [IDX_W-1:0]  tx_idx,
    input  logic              tx_ready,
    input  logic              tx_error,
    output logic [WORD_W-1:0] state_word,
    output logic              not_full,
    output logic [CNT_W-1:0]  frame_cnt,
    output logic              ev_txdone,
    output logic              ev_bufchg
);

    typedef struct packed {
        logic [WORD_W-1:0] st;
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic              ev_done;
        logic              ev_chg;
    } sched_t;

    sched_t r_q, r_d;

    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic              launch;
    logic              complete;
    logic [BUF_N-1:0]  lock_mask;
    logic [BUF_N-1:0]  apply_mask;
    logic [WORD_W-1:0] cmd_word;

    txs_picker #(
        .BUF_N  (BUF_N),
        .PRIO_W (PRIO_W)
    ) u_picker (
        .state_word (r_q.st),
        .prio_word  (prio_word),
        .found      (pick_found),
        .pick_idx   (pick_idx)
    );

    assign launch   = ctrl_en && !r_q.busy && pick_found;
    assign complete = r_q.busy && tx_ready;

    // Buffer in flight, or being launched this cycle, is shielded from commands.
    always_comb begin
        for (int i = 0; i < BUF_N; i++) begin
            lock_mask[i] = (r_q.busy && r_q.idx == IDX_W'(i)) ||
                           (launch && pick_idx == IDX_W'(i));
        end
        apply_mask = (cmd_valid && ctrl_en) ? (cmd_sel & ~lock_mask) : '0;
    end

    txs_cmd_unit #(
        .BUF_N (BUF_N)
    ) u_cmd (
        .cur_word   (r_q.st),
        .apply_mask (apply_mask),
        .do_abort   (cmd_abort),
        .do_ready   (cmd_set_ready),
        .do_empty   (cmd_set_empty),
        .nxt_word   (cmd_word)
    );

    always_comb begin
        r_d         = r_q;
        r_d.st      = cmd_word;
        r_d.ev_done = 1'b0;

        if (complete) begin
            r_d.st[r_q.idx*FIELD_W +: FIELD_W] = tx_error ? ST_FAILED : ST_SENT;
            r_d.busy    = 1'b0;
            r_d.ev_done = 1'b1;
            if (!tx_error) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else if (launch) begin
            r_d.busy = 1'b1;
            r_d.idx  = pick_idx;
        end

        if (cnt_clr) begin
            r_d.cnt = '0;
        end

        r_d.ev_chg = (r_d.st != r_q.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= '0;
            r_q.busy    <= 1'b0;
            r_q.idx     <= '0;
            r_q.cnt     <= '0;
            r_q.ev_done <= 1'b0;
            r_q.ev_chg  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        not_full = 1'b0;
        for (int i = 0; i < BUF_N; i++) begin
            if (r_q.st[i*FIELD_W +: FIELD_W] == ST_EMPTY) begin
                not_full = 1'b1;
            end
        end
    end

    assign tx_valid   = r_q.busy;
    assign tx_idx     = r_q.idx;
    assign state_word = r_q.st;
    assign frame_cnt  = r_q.cnt;
    assign ev_txdone  = r_q.ev_done;
    assign ev_bufchg  = r_q.ev_chg;

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_idx))); // R6

    AST_INFLIGHT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (state_word[tx_idx*FIELD_W +: FIELD_W] == ST_READY)); // R7

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !(tx_valid && tx_ready)) |=> $stable(state_word)); // R4

    AST_NO_LAUNCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !tx_valid) |=> !tx_valid); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (ev_txdone && ev_bufchg && !tx_valid)); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_error && !cnt_clr) |=>
            (frame_cnt == $past(frame_cnt) + 1'b1)); // R9

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (frame_cnt == '0)); // R9

endmodule

// File: tb/test_txbuf_sched.sv
`timescale 1ns/1ps
module test_txbuf_sched;

    localparam int BUF_N = 4;
    localparam int WORD_W = 4 * BUF_N;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_en = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [BUF_N-1:0]  cmd_sel = '0;
    logic              cmd_abort = 1'b0;
    logic              cmd_set_ready = 1'b0;
    logic              cmd_set_empty = 1'b0;
    logic [WORD_W-1:0] prio_word = '0;
    logic              cnt_clr = 1'b0;
    logic              tx_valid;
    logic [1:0]        tx_idx;
    logic              tx_ready = 1'b0;
    logic              tx_error = 1'b0;
    logic [WORD_W-1:0] state_word;
    logic              not_full;
    logic [31:0]       frame_cnt;
    logic              ev_txdone;
    logic              ev_bufchg;

    int n_checks = 0;
    int n_fail   = 0;
    int done_seen = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    txbuf_sched i_txbuf_sched (
        .clk (clk), .rst_n (rst_n), .ctrl_en (ctrl_en),
        .cmd_valid (cmd_valid), .cmd_sel (cmd_sel), .cmd_abort (cmd_abort),
        .cmd_set_ready (cmd_set_ready), .cmd_set_empty (cmd_set_empty),
        .prio_word (prio_word), .cnt_clr (cnt_clr),
        .tx_valid (tx_valid), .tx_idx (tx_idx), .tx_ready (tx_ready),
        .tx_error (tx_error), .state_word (state_word), .not_full (not_full),
        .frame_cnt (frame_cnt), .ev_txdone (ev_txdone), .ev_bufchg (ev_bufchg)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: each accepted offer is compared with the next expected index.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected launch", 32'(tx_idx), 32'hFFFF_FFFF);
            end else begin
                check("R5 launch order", 32'(tx_idx), 32'(exp_q.pop_front()));
            end
        end
        if (rst_n && ev_txdone) done_seen++;
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_cmd(input logic [BUF_N-1:0] sel, input logic ab,
                          input logic rd, input logic em);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_sel = sel;
        cmd_abort = ab; cmd_set_ready = rd; cmd_set_empty = em;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_sel = '0;
        cmd_abort = 1'b0; cmd_set_ready = 1'b0; cmd_set_empty = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        @(negedge clk);
        check("R1 state after reset", 32'(state_word), 32'h0);
        check("R1 counter after reset", frame_cnt, 32'h0);
        check("R1 tx_valid after reset", 32'(tx_valid), 32'h0);
        check("R10 not_full after reset", 32'(not_full), 32'h1);

        // Disabled: command and launch are both suppressed.
        prio_word = 16'h0552; // b3=0, b2=5, b1=5, b0=2
        do_cmd(4'hF, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R4 bufchg while disabled", 32'(ev_bufchg), 32'h0);
        step(2);
        @(negedge clk);
        check("R4 states frozen while disabled", 32'(state_word), 32'h0);

        // Enabled: all ready, bus stalled.
        ctrl_en = 1'b1;
        do_cmd(4'hF, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R8 bufchg after set-ready", 32'(ev_bufchg), 32'h1);
        check("R2 all fields READY", 32'(state_word), 32'h1111);
        check("R10 not_full with none empty", 32'(not_full), 32'h0);
        step(3);
        @(negedge clk);
        check("R6 offer raised", 32'(tx_valid), 32'h1);
        check("R5 tie goes to lower index", 32'(tx_idx), 32'h1);
        step(3);
        @(negedge clk);
        check("R6 offer held", 32'(tx_valid), 32'h1);
        check("R6 index held", 32'(tx_idx), 32'h1);

        // Release: order 1, 2, 0; buffer 3 at priority 0 never goes.
        exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(0);
        step(1);
        tx_ready = 1'b1;
        step(15);
        tx_ready = 1'b0;
        step(1);
        @(negedge clk);
        check("R5 all expected launches seen", 32'(exp_q.size()), 32'h0);
        check("R8 states after sends", 32'(state_word), 32'h1222);
        check("R9 count after three sends", frame_cnt, 32'd3);
        check("R5 priority-0 buffer not offered", 32'(tx_valid), 32'h0);
        check("R8 done pulses", 32'(done_seen), 32'd3);

        // Command ordering on buffer 3 (READY, never offered).
        do_cmd(4'h8, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check("R3 abort then empty", 32'(state_word[15:12]), 32'h0);
        check("R10 not_full with one empty", 32'(not_full), 32'h1);
        do_cmd(4'h8, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R3 ready then empty keeps READY", 32'(state_word[15:12]), 32'h1);
        do_cmd(4'h8, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 abort on READY", 32'(state_word[15:12]), 32'h4);
        do_cmd(4'h8, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R3 empty on ABORTED", 32'(state_word[15:12]), 32'h0);
        do_cmd(4'h2, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R3 empty on SENT", 32'(state_word[7:4]), 32'h0);

        // In-flight lock and failed completion on buffer 0.
        do_cmd(4'h1, 1'b0, 1'b1, 1'b0);
        step(2);
        @(negedge clk);
        check("R6 buffer 0 offered", 32'(tx_valid), 32'h1);
        check("R5 only eligible index", 32'(tx_idx), 32'h0);
        do_cmd(4'h1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 abort ignored in flight", 32'(state_word[3:0]), 32'h1);
        check("R7 no change event", 32'(ev_bufchg), 32'h0);
        exp_q.push_back(0);
        tx_error = 1'b1; tx_ready = 1'b1;
        step(1);
        tx_error = 1'b0; tx_ready = 1'b0;
        @(negedge clk);
        check("R8 failed completion state", 32'(state_word[3:0]), 32'h3);
        check("R8 done pulse on failure", 32'(ev_txdone), 32'h1);
        check("R9 no count on failure", frame_cnt, 32'd3);
        do_cmd(4'h1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R3 empty on FAILED", 32'(state_word[3:0]), 32'h0);

        // Counter clear.
        cnt_clr = 1'b1;
        step(1);
        cnt_clr = 1'b0;
        @(negedge clk);
        check("R9 counter cleared", frame_cnt, 32'h0);
        check("R8 total done pulses", 32'(done_seen), 32'd4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule